// File: doc/BRIEF.md
# I2C Byte-Wait and Release Controller

This block sits inside an I2C bus interface and decides when the interface stretches SCL low between bytes. A counter outside the block reports each completed SCL clock, numbered 1 to 9 within a byte. A wait-point select picks where the wait begins. With the select set, the wait starts after the ninth clock, which is the acknowledge clock. With the select clear, it starts after the eighth clock, the last data clock. While the wait flag is set, the block requests that SCL be held low. SCL is treated as a wired-AND line, so a second device can also be holding it low.

The wait ends only when software acts, and the actions that count depend on the device's role and direction:
- A receiver may write an all-ones byte to the data register or pulse the release bit.
- A transmitter releases by writing its next byte, which is then handed on to be shifted out.
- A master may also end its own wait by requesting a repeated start or a stop.

Each release reports a cause code for one cycle. When several release requests arrive in the same cycle, one fixed priority picks the cause. During the acknowledge clock, a receiver drives SDA low if the ACK enable was set when the eighth clock completed.

Top module: `i2c_wait_ctrl`

## Requirements
- R1: With `wait_on_ack`=1, a `bit_done` pulse with `bit_cnt`=9 (DATA_W+1) sets `wait_flag` and `scl_hold` on that clock edge. A `bit_done` pulse with `bit_cnt`=8 leaves them low.
- R2: With `wait_on_ack`=0, a `bit_done` pulse with `bit_cnt`=8 (DATA_W) sets `wait_flag` and `scl_hold` on that clock edge. The following ninth-clock pulse does not set them again after a release.
- R3: The block samples `ack_en` on the edge that registers the eighth-clock pulse.
  - A receiver (`is_tx`=0) drives `sda_ack_low`=1 from that edge until the edge that registers the ninth-clock pulse, but only if the sampled `ack_en` was 1.
  - Changing `ack_en` after the sample has no effect on that byte.
  - A transmitter never drives `sda_ack_low`.
- R4: For a receiver in a wait, a `data_wr` with `data_in` all ones clears the wait and reports `rel_cause`=1. A `data_wr` of any other value leaves the wait in place.
- R5: For a receiver in a wait, `rel_wr` clears the wait and reports `rel_cause`=2. For a transmitter, `rel_wr` leaves the wait in place. `rel_rb` reads 1 in exactly the one cycle after a `rel_wr` pulse and 0 after that.
- R6: For a transmitter in a wait, a `data_wr` of any value clears the wait, reports `rel_cause`=3 and copies `data_in` to `tx_byte`.
- R7: For a master in a wait:
  - `start_req` clears the wait and reports `rel_cause`=4.
  - `stop_req` clears the wait and reports `rel_cause`=5.
  - For a slave, neither request has any effect.
- R8: When release requests coincide, the cause is chosen in the order stop, then start, then data write, then release bit. `tx_byte` changes only when the chosen cause is 3.
- R9: A release request made while no wait is pending leaves `wait_flag` at 0 and `rel_cause` at 0.
- R10: When two devices share SCL and both wait after the ninth clock, the wired-AND line stays low until both have released.
- R11: `rel_cause` is valid for exactly one cycle after the releasing edge and is 0 otherwise. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = device is bus master |
| is_tx | input | 1 | 1 = device transmits the current byte |
| wait_on_ack | input | 1 | 1 = wait after clock 9, 0 = wait after clock 8 |
| ack_en | input | 1 | ACK enable; 1 = receiver pulls SDA low on clock 9 |
| rel_wr | input | 1 | One-cycle write of 1 to the release bit |
| start_req | input | 1 | One-cycle repeated-start request |
| stop_req | input | 1 | One-cycle stop request |
| bit_done | input | 1 | Pulse when an SCL clock of the byte completes |
| bit_cnt | input | CNT_W | Number (1..DATA_W+1) of the clock that completed |
| data_wr | input | 1 | Data-register write strobe |
| data_in | input | DATA_W | Data-register write value |
| scl_hold | output | 1 | Request to hold SCL low |
| sda_ack_low | output | 1 | Drive SDA low for acknowledge |
| wait_flag | output | 1 | Wait pending |
| rel_rb | output | 1 | Release-bit readback (self-clearing) |
| rel_cause | output | 3 | Release cause: 0 none, 1 all-ones write, 2 release bit, 3 tx data, 4 restart, 5 stop |
| tx_byte | output | DATA_W | Byte that released a transmitter wait |

## Verification
The embedded properties check the following on every cycle:
- A wait flag rises only in response to a completed clock.
- Any release decision clears the flag on the next edge.
- A cause code never appears unless a wait was pending.
- The release-bit readback drops by itself.
- The acknowledge drive ends at the ninth clock.

Some behaviours can only be shown by the directed scenarios:
- which actions count as a release for each role and direction, and which are ignored;
- the priority when requests coincide;
- the latching of ACK enable at the eighth clock;
- the wired-AND interplay of two devices waiting at once.

// File: rtl/i2c_wait_pkg.sv
package i2c_wait_pkg;

   typedef enum logic [2:0] {
      REL_NONE    = 3'd0,
      REL_RX_FF   = 3'd1,
      REL_RX_BIT  = 3'd2,
      REL_TX_DATA = 3'd3,
      REL_RESTART = 3'd4,
      REL_STOP    = 3'd5
   } rel_cause_e;

endpackage

// File: rtl/i2c_wait_entry.sv
module i2c_wait_entry #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_done,
   input  logic [CNT_W-1:0] bit_cnt,
   input  logic             wait_on_ack,
   input  logic             ack_en,
   input  logic             is_tx,
   output logic             enter,
   output logic             sda_ack_low
);
   localparam logic [CNT_W-1:0] CLK_LAST_DATA = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CLK_ACK       = CNT_W'(DATA_W + 1);

   logic hit_data;
   logic hit_ack;
   logic ack_phase_q;
   logic ack_lat_q;

   assign hit_data = bit_done && (bit_cnt == CLK_LAST_DATA);
   assign hit_ack  = bit_done && (bit_cnt == CLK_ACK);
   assign enter    = wait_on_ack ? hit_ack : hit_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_phase_q <= 1'b0;
         ack_lat_q   <= 1'b0;
      end else if (hit_data) begin
         ack_phase_q <= 1'b1;
         ack_lat_q   <= ack_en;
      end else if (hit_ack) begin
         ack_phase_q <= 1'b0;
      end
   end

   assign sda_ack_low = ack_phase_q & ack_lat_q & ~is_tx;

   AST_ACK_ENDS_AT_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ack |=> !sda_ack_low); // R3

   AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_data && !ack_en |=> !sda_ack_low); // R3

endmodule

// File: rtl/i2c_wait_release.sv
module i2c_wait_release
   import i2c_wait_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit RX_FF_RELEASE = 1'b1
) (
   input  logic              wait_q,
   input  logic              is_master,
   input  logic              is_tx,
   input  logic              rel_wr,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   output logic              rel_hit,
   output rel_cause_e        rel_sel
);
   logic cand_stop;
   logic cand_start;
   logic cand_tx;
   logic cand_ff;
   logic cand_bit;

   assign cand_stop  = is_master & stop_req;
   assign cand_start = is_master & start_req;
   assign cand_tx    = is_tx & data_wr;
   assign cand_bit   = ~is_tx & rel_wr;

   generate
      if (RX_FF_RELEASE) begin : g_ff_release
         assign cand_ff = ~is_tx & data_wr & (&data_in);
      end else begin : g_no_ff_release
         logic unused_data;
         assign unused_data = ^data_in;
         assign cand_ff     = 1'b0;
      end
   endgenerate

   always_comb begin
      rel_sel = REL_NONE;
      if (wait_q) begin
         if (cand_stop)       rel_sel = REL_STOP;
         else if (cand_start) rel_sel = REL_RESTART;
         else if (cand_tx)    rel_sel = REL_TX_DATA;
         else if (cand_ff)    rel_sel = REL_RX_FF;
         else if (cand_bit)   rel_sel = REL_RX_BIT;
      end
   end

   assign rel_hit = (rel_sel != REL_NONE);

endmodule

// File: rtl/i2c_wait_ctrl.sv
module i2c_wait_ctrl
   import i2c_wait_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit RX_FF_RELEASE = 1'b1,
   parameter int CNT_W         = $clog2(DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_master,
   input  logic              is_tx,
   input  logic              wait_on_ack,
   input  logic              ack_en,
   input  logic              rel_wr,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              bit_done,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   output logic              scl_hold,
   output logic              sda_ack_low,
   output logic              wait_flag,
   output logic              rel_rb,
   output logic [2:0]        rel_cause,
   output logic [DATA_W-1:0] tx_byte
);
   localparam int MIN_CNT_W = $clog2(DATA_W + 2);

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("i2c_wait_ctrl: DATA_W must be 2..16");
      end
      if (CNT_W < MIN_CNT_W) begin : g_bad_cnt
         $error("i2c_wait_ctrl: CNT_W too narrow for DATA_W+1");
      end
   endgenerate

   logic              enter;
   logic              rel_hit;
   rel_cause_e        rel_sel;
   logic              wait_q;
   rel_cause_e        cause_q;
   logic              rb_q;
   logic [DATA_W-1:0] txb_q;

   i2c_wait_entry #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_done    (bit_done),
      .bit_cnt     (bit_cnt),
      .wait_on_ack (wait_on_ack),
      .ack_en      (ack_en),
      .is_tx       (is_tx),
      .enter       (enter),
      .sda_ack_low (sda_ack_low)
   );

   i2c_wait_release #(.DATA_W(DATA_W), .RX_FF_RELEASE(RX_FF_RELEASE)) u_release (
      .wait_q    (wait_q),
      .is_master (is_master),
      .is_tx     (is_tx),
      .rel_wr    (rel_wr),
      .start_req (start_req),
      .stop_req  (stop_req),
      .data_wr   (data_wr),
      .data_in   (data_in),
      .rel_hit   (rel_hit),
      .rel_sel   (rel_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q  <= 1'b0;
         cause_q <= REL_NONE;
         rb_q    <= 1'b0;
         txb_q   <= '0;
      end else begin
         rb_q    <= rel_wr;
         cause_q <= rel_sel;
         if (rel_hit)    wait_q <= 1'b0;
         else if (enter) wait_q <= 1'b1;
         if (rel_sel == REL_TX_DATA) txb_q <= data_in;
      end
   end

   assign scl_hold  = wait_q;
   assign wait_flag = wait_q;
   assign rel_rb    = rb_q;
   assign rel_cause = cause_q;
   assign tx_byte   = txb_q;

   AST_ENTRY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      enter && !wait_q |=> wait_q); // R1

   AST_RISE_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_q) |-> $past(bit_done)); // R2

   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rel_hit |=> !wait_flag && (rel_cause != 3'd0)); // R4

   AST_CAUSE_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_cause != 3'd0) |-> $past(wait_q)); // R9

   AST_RB_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rel_rb && !rel_wr |=> !rel_rb); // R5

   AST_TXBYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_cause != 3'd3) |-> $stable(tx_byte)); // R8

endmodule

// File: tb/tb_i2c_wait_ctrl.sv
module tb_i2c_wait_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_master = 0, is_tx = 0, wait_on_ack = 1, ack_en = 0;
   logic       rel_wr = 0, start_req = 0, stop_req = 0, data_wr = 0;
   logic       bit_done = 0;
   logic [3:0] bit_cnt = 0;
   logic [7:0] data_in = 0;
   logic       scl_hold, sda_ack_low, wait_flag, rel_rb;
   logic [2:0] rel_cause;
   logic [7:0] tx_byte;

   logic       p_rel_wr = 0;
   logic       p_scl_hold, p_sda, p_wait, p_rb;
   logic [2:0] p_cause;
   logic [7:0] p_txb;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   i2c_wait_ctrl dut (
      .clk(clk), .rst_n(rst_n), .is_master(is_master), .is_tx(is_tx),
      .wait_on_ack(wait_on_ack), .ack_en(ack_en), .rel_wr(rel_wr),
      .start_req(start_req), .stop_req(stop_req), .bit_done(bit_done),
      .bit_cnt(bit_cnt), .data_wr(data_wr), .data_in(data_in),
      .scl_hold(scl_hold), .sda_ack_low(sda_ack_low), .wait_flag(wait_flag),
      .rel_rb(rel_rb), .rel_cause(rel_cause), .tx_byte(tx_byte)
   );

   i2c_wait_ctrl peer (
      .clk(clk), .rst_n(rst_n), .is_master(1'b0), .is_tx(1'b0),
      .wait_on_ack(1'b1), .ack_en(1'b1), .rel_wr(p_rel_wr),
      .start_req(1'b0), .stop_req(1'b0), .bit_done(bit_done),
      .bit_cnt(bit_cnt), .data_wr(1'b0), .data_in(8'h00),
      .scl_hold(p_scl_hold), .sda_ack_low(p_sda), .wait_flag(p_wait),
      .rel_rb(p_rb), .rel_cause(p_cause), .tx_byte(p_txb)
   );

   logic bus_scl;
   assign bus_scl = ~(scl_hold | p_scl_hold);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clk_ev(input int n);
      bit_cnt  = 4'(n);
      bit_done = 1'b1;
      @(negedge clk);
      bit_done = 1'b0;
   endtask

   task automatic run_to(input int last);
      for (int i = 1; i <= last; i++) clk_ev(i);
   endtask

   task automatic pulse(input logic w_rel, input logic w_start, input logic w_stop,
                        input logic w_data, input logic [7:0] val);
      rel_wr = w_rel; start_req = w_start; stop_req = w_stop;
      data_wr = w_data; data_in = val;
      @(negedge clk);
      rel_wr = 0; start_req = 0; stop_req = 0; data_wr = 0;
   endtask

   task automatic t_reset;
      chk("R11 reset scl_hold", scl_hold, 0);
      chk("R11 reset sda", sda_ack_low, 0);
      chk("R11 reset cause", rel_cause, 0);
      chk("R11 reset rb", rel_rb, 0);
      chk("R11 reset tx_byte", tx_byte, 0);
   endtask

   task automatic t_wait_ninth_rx;
      is_master = 0; is_tx = 0; wait_on_ack = 1; ack_en = 1;
      run_to(8);
      chk("R1 no wait at 8", wait_flag, 0);
      chk("R3 ack driven after 8", sda_ack_low, 1);
      clk_ev(9);
      chk("R1 wait after 9", wait_flag, 1);
      chk("R1 hold after 9", scl_hold, 1);
      chk("R3 ack off after 9", sda_ack_low, 0);
      pulse(0, 0, 0, 1, 8'h12);
      chk("R4 non-FF keeps wait", wait_flag, 1);
      chk("R4 non-FF no cause", rel_cause, 0);
      pulse(0, 0, 0, 1, 8'hFF);
      chk("R4 FF releases", wait_flag, 0);
      chk("R4 FF cause", rel_cause, 1);
      @(negedge clk);
      chk("R11 cause one cycle", rel_cause, 0);
   endtask

   task automatic t_wait_eighth_rx;
      is_master = 0; is_tx = 0; wait_on_ack = 0; ack_en = 0;
      run_to(8);
      chk("R2 wait after 8", wait_flag, 1);
      chk("R3 no ack when disabled", sda_ack_low, 0);
      pulse(1, 0, 0, 0, 8'h00);
      chk("R5 rel bit releases", wait_flag, 0);
      chk("R5 rel bit cause", rel_cause, 2);
      chk("R5 readback high", rel_rb, 1);
      @(negedge clk);
      chk("R5 readback self-clears", rel_rb, 0);
      clk_ev(9);
      chk("R2 no wait at 9", wait_flag, 0);
   endtask

   task automatic t_ack_latch;
      is_master = 0; is_tx = 0; wait_on_ack = 1; ack_en = 1;
      run_to(8);
      ack_en = 0;
      @(negedge clk);
      chk("R3 ack uses latched enable", sda_ack_low, 1);
      clk_ev(9);
      pulse(1, 0, 0, 0, 8'h00);
      chk("R5 release after latch test", wait_flag, 0);
   endtask

   task automatic t_tx_slave;
      is_master = 0; is_tx = 1; wait_on_ack = 1; ack_en = 1;
      run_to(8);
      chk("R3 transmitter no ack", sda_ack_low, 0);
      clk_ev(9);
      chk("R1 tx wait after 9", wait_flag, 1);
      pulse(1, 0, 0, 0, 8'h00);
      chk("R5 rel bit ignored on tx", wait_flag, 1);
      pulse(0, 0, 0, 1, 8'hA5);
      chk("R6 tx write releases", wait_flag, 0);
      chk("R6 tx cause", rel_cause, 3);
      chk("R6 tx byte", tx_byte, 8'hA5);
   endtask

   task automatic t_master_start_stop;
      is_master = 1; is_tx = 0; wait_on_ack = 1;
      run_to(9);
      pulse(0, 1, 0, 0, 8'h00);
      chk("R7 start releases", wait_flag, 0);
      chk("R7 start cause", rel_cause, 4);
      run_to(9);
      pulse(0, 0, 1, 0, 8'h00);
      chk("R7 stop releases", wait_flag, 0);
      chk("R7 stop cause", rel_cause, 5);
      is_master = 0;
      run_to(9);
      pulse(0, 1, 1, 0, 8'h00);
      chk("R7 slave start/stop ignored", wait_flag, 1);
      chk("R7 slave no cause", rel_cause, 0);
      pulse(1, 0, 0, 0, 8'h00);
   endtask

   task automatic t_priority;
      is_master = 1; is_tx = 1; wait_on_ack = 1;
      run_to(9);
      pulse(0, 1, 1, 1, 8'h3C);
      chk("R8 stop wins", rel_cause, 5);
      chk("R8 tx_byte kept", tx_byte, 8'hA5);
      run_to(9);
      pulse(0, 1, 0, 1, 8'h3C);
      chk("R8 start over data", rel_cause, 4);
      is_master = 0; is_tx = 0;
      run_to(9);
      pulse(1, 0, 0, 1, 8'hFF);
      chk("R8 data over rel bit", rel_cause, 1);
   endtask

   task automatic t_idle_release;
      is_master = 1; is_tx = 0;
      pulse(1, 1, 0, 1, 8'hFF);
      chk("R9 idle wait stays 0", wait_flag, 0);
      chk("R9 idle cause 0", rel_cause, 0);
   endtask

   task automatic t_wired_and;
      is_master = 1; is_tx = 1; wait_on_ack = 1;
      run_to(9);
      chk("R10 both waiting", bus_scl, 0);
      pulse(0, 0, 0, 1, 8'h77);
      chk("R10 master released", wait_flag, 0);
      chk("R10 line still low", bus_scl, 0);
      p_rel_wr = 1;
      @(negedge clk);
      p_rel_wr = 0;
      chk("R10 line released", bus_scl, 1);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_wait_ninth_rx();
      t_wait_eighth_rx();
      t_ack_latch();
      t_tx_slave();
      t_master_start_stop();
      t_priority();
      t_idle_release();
      t_wired_and();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule